// File: doc/BRIEF.md
# Predicated Vector Sum Reduction Unit

This unit reduces one vector of integer lanes to a single total. Each cycle it may accept a source vector together with a predicate mask that carries one bit per lane. Every lane whose mask bit is set takes part in the sum. Every lane whose bit is clear adds nothing, whatever its data holds. The result comes back in the same vector shape as the source: lane 0 holds the total and all the other lanes read as zero.

Inside the unit, the selected lanes are widened and fed into a balanced tree of pairwise adders with one register stage per tree level. Because the adders are wide enough for the exact sum, no carry is lost inside the tree. The value returned in lane 0 is that exact sum cut down to the element width, so the low bits wrap the same way whether the lanes are read as signed or unsigned numbers.

The valid strobe travels through the tree alongside the data. A new vector can be accepted on every cycle and the unit never stalls. The lane count must be a power of two of at least 2, and the element width is expected to be 16, 32 or 64 bits.

Top module: `vsum_reduce`

## Requirements
- R1: When a result is valid, output lane 0 (bits ELEM_W-1:0 of `out_data`) equals the sum of the source lanes whose mask bit is one, reduced modulo 2^ELEM_W. Lane i of `in_data` occupies bits i*ELEM_W +: ELEM_W and is selected by `in_mask[i]`.
- R2: Output lanes 1 through LANES-1 (bits LANES*ELEM_W-1:ELEM_W of `out_data`) are zero on every cycle.
- R3: A lane whose mask bit is zero adds nothing to the sum, whatever its data value.
- R4: When every mask bit of an accepted vector is zero, the whole output vector for that vector is zero, lane 0 included.
- R5: Lanes are added at a width of ELEM_W+log2(LANES) bits, so a total that exceeds the element range (for example, every lane at its maximum value) returns exactly the low ELEM_W bits of the true sum.
- R6: `out_valid` rises exactly log2(LANES) clock cycles after the cycle in which `in_valid` was sampled high, and it is never high without a matching input.
- R7: Vectors presented on consecutive cycles are all accepted, and their results come out one per cycle in the order the vectors went in.
- R8: While `rst_n` is low, and after it is released until the first accepted vector has passed through the tree, `out_valid` stays low. Data presented while `in_valid` is low produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the pipeline valid bits |
| in_valid | input | 1 | High when a source vector is presented this cycle |
| in_data | input | LANES*ELEM_W | Source vector, lane i in bits i*ELEM_W +: ELEM_W |
| in_mask | input | LANES | Predicate, one bit per lane; 1 means the lane is summed |
| out_valid | output | 1 | High when `out_data` carries a result |
| out_data | output | LANES*ELEM_W | Result vector: lane 0 holds the sum, all other lanes are zero |

## Verification
The hardest case to reach from the ports is a long burst of back-to-back vectors with mixed masks and large lane values. In that case every tree level holds a different vector, and the wide intermediate sums cross the element range while results stream out each cycle. The stimulus builds this by driving a run of random vectors and masks on consecutive cycles, with no gaps. Saturated all-ones lanes, lone high-index lanes and all-clear masks with nonzero data are placed between the random vectors. A scoreboard queue records each expected total and the cycle it is due, so a result that is late, missing, reordered or wrongly wrapped is caught.

// File: rtl/vsum_pkg.sv
// Package: shared helpers for the predicated vector sum reduction.
// Assumes lane counts are powers of two no smaller than 2.
package vsum_pkg;

    // Number of adder tree levels for a given lane count.
    function automatic int tree_levels(input int lanes);
        return $clog2(lanes);
    endfunction

    // Width of the internal adders: wide enough for the exact sum of all lanes.
    function automatic int acc_width(input int lanes, input int elem_w);
        return elem_w + $clog2(lanes);
    endfunction

endpackage

// File: rtl/vsum_mask_extend.sv
// Module: vsum_mask_extend
// Zero-extends every lane to the accumulator width and replaces lanes whose
// predicate bit is clear with zero. Purely combinational.
// Assumes ACC_W >= ELEM_W.
module vsum_mask_extend #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16,
    parameter int ACC_W  = 19
) (
    input  logic [LANES*ELEM_W-1:0] src_vec,
    input  logic [LANES-1:0]        src_mask,
    output logic [LANES*ACC_W-1:0]  wide_vec
);

    localparam int PAD_W = ACC_W - ELEM_W;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        // Select one lane: widen when its predicate is set, otherwise zero.
        always_comb begin
            if (src_mask[ln]) begin
                wide_vec[ln*ACC_W +: ACC_W] = {{PAD_W{1'b0}}, src_vec[ln*ELEM_W +: ELEM_W]};
            end else begin
                wide_vec[ln*ACC_W +: ACC_W] = '0;
            end
        end
    end

endmodule

// File: rtl/vsum_tree_level.sv
// Module: vsum_tree_level
// One level of the balanced adder tree: adds neighbouring pairs of IN_CNT
// inputs and registers the IN_CNT/2 results along with the valid bit.
// Data registers load only on valid input; the valid register is cleared by
// the synchronous active-low reset.
// Assumes IN_CNT is even and that every input value at level LEVEL fits in
// ELEM_W+LEVEL bits, so no result carries out of ACC_W.
module vsum_tree_level #(
    parameter int IN_CNT = 8,
    parameter int ACC_W  = 19,
    parameter int ELEM_W = 16,
    parameter int LEVEL  = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lvl_in_valid,
    input  logic [IN_CNT*ACC_W-1:0]     lvl_in_vec,
    output logic                        lvl_out_valid,
    output logic [(IN_CNT/2)*ACC_W-1:0] lvl_out_vec
);

    localparam int OUT_CNT = IN_CNT / 2;
    localparam int FIT_W   = ELEM_W + LEVEL + 1;

    logic [OUT_CNT*ACC_W-1:0] pair_sum;

    for (genvar pr = 0; pr < OUT_CNT; pr++) begin : g_pair
        // Add the two neighbouring inputs of this pair.
        always_comb begin
            pair_sum[pr*ACC_W +: ACC_W] = lvl_in_vec[(2*pr)*ACC_W +: ACC_W]
                                        + lvl_in_vec[(2*pr+1)*ACC_W +: ACC_W];
        end
    end

    // Move the valid bit one stage down the tree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_out_valid <= 1'b0;
        end else begin
            lvl_out_valid <= lvl_in_valid;
        end
    end

    // Capture the pair sums when a vector is present.
    always_ff @(posedge clk) begin
        if (lvl_in_valid) begin
            lvl_out_vec <= pair_sum;
        end
    end

    AST_VALID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_in_valid |=> lvl_out_valid); // R6

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_in_valid |=> !lvl_out_valid); // R8

    AST_ZERO_PASSES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_in_valid && (lvl_in_vec == '0)) |=> (lvl_out_vec == '0)); // R4

    for (genvar ck = 0; ck < OUT_CNT; ck++) begin : g_fit
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_out_valid |-> ((lvl_out_vec[ck*ACC_W +: ACC_W] >> FIT_W) == '0)); // R5
    end

endmodule

// File: rtl/vsum_lane_pack.sv
// Module: vsum_lane_pack
// Places the low ELEM_W bits of the wide total into lane 0 of the result
// vector and drives every other lane with zero. Purely combinational.
// Assumes LANES >= 2.
module vsum_lane_pack #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16,
    parameter int ACC_W  = 19
) (
    input  logic [ACC_W-1:0]        total_wide,
    output logic [LANES*ELEM_W-1:0] res_vec
);

    localparam int HI_W = (LANES - 1) * ELEM_W;

    // Truncate the total into lane 0 and clear the upper lanes.
    always_comb begin
        res_vec = {{HI_W{1'b0}}, total_wide[ELEM_W-1:0]};
    end

endmodule

// File: rtl/vsum_reduce.sv
// Module: vsum_reduce (top)
// Predicated vector sum reduction. Masked lanes are widened, summed through
// a balanced adder tree with one register per level (latency log2(LANES)),
// and the truncated total is returned in lane 0 with all other lanes zero.
// Accepts one vector per cycle with no back-pressure.
// Assumes LANES is a power of two >= 2 and ELEM_W is 16, 32 or 64.
module vsum_reduce #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*ELEM_W-1:0] in_data,
    input  logic [LANES-1:0]        in_mask,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] out_data
);

    localparam int LEVELS = vsum_pkg::tree_levels(LANES);
    localparam int ACC_W  = vsum_pkg::acc_width(LANES, ELEM_W);

    logic [LANES*ACC_W-1:0] masked_vec;
    logic [ACC_W-1:0]       total_q;

    vsum_mask_extend #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W),
        .ACC_W  (ACC_W)
    ) u_mask (
        .src_vec  (in_data),
        .src_mask (in_mask),
        .wide_vec (masked_vec)
    );

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        localparam int IN_CNT  = LANES >> lv;
        localparam int OUT_CNT = IN_CNT / 2;

        logic                     vld_q;
        logic [OUT_CNT*ACC_W-1:0] sum_q;
        logic                     vld_in;
        logic [IN_CNT*ACC_W-1:0]  vec_in;

        if (lv == 0) begin : g_src
            // First level reads the masked, widened lanes.
            always_comb begin
                vld_in = in_valid;
                vec_in = masked_vec;
            end
        end else begin : g_src
            // Later levels read the registers of the level above.
            always_comb begin
                vld_in = g_lvl[lv-1].vld_q;
                vec_in = g_lvl[lv-1].sum_q;
            end
        end

        vsum_tree_level #(
            .IN_CNT (IN_CNT),
            .ACC_W  (ACC_W),
            .ELEM_W (ELEM_W),
            .LEVEL  (lv)
        ) u_level (
            .clk           (clk),
            .rst_n         (rst_n),
            .lvl_in_valid  (vld_in),
            .lvl_in_vec    (vec_in),
            .lvl_out_valid (vld_q),
            .lvl_out_vec   (sum_q)
        );
    end

    // Take the single total and its valid bit from the last level.
    always_comb begin
        total_q   = g_lvl[LEVELS-1].sum_q;
        out_valid = g_lvl[LEVELS-1].vld_q;
    end

    vsum_lane_pack #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W),
        .ACC_W  (ACC_W)
    ) u_pack (
        .total_wide (total_q),
        .res_vec    (out_data)
    );

    for (genvar ml = 0; ml < LANES; ml++) begin : g_mchk
        AST_MASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !in_mask[ml] |-> (masked_vec[ml*ACC_W +: ACC_W] == '0)); // R3
    end

    AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_data[LANES*ELEM_W-1:ELEM_W] == '0); // R2

endmodule

// File: tb/sim_vsum_reduce.sv
// Scoreboard bench for vsum_reduce: the driver pushes expected totals with
// their due cycle, the monitor pops and compares as results appear.
module sim_vsum_reduce;

    localparam int LANES  = 8;
    localparam int ELEM_W = 16;
    localparam int LAT    = $clog2(LANES);

    typedef struct {
        logic [ELEM_W-1:0] lane0;
        int                due;
        string             tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [LANES*ELEM_W-1:0] in_data = '0;
    logic [LANES-1:0]        in_mask = '0;
    logic                    out_valid;
    logic [LANES*ELEM_W-1:0] out_data;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    vsum_reduce #(.LANES(LANES), .ELEM_W(ELEM_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_mask   (in_mask),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Drive one vector and record its expected lane-0 total.
    task automatic drive(input logic [LANES*ELEM_W-1:0] d, input logic [LANES-1:0] m, input string tag);
        exp_t   e;
        longint s = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_mask  = m;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) s += longint'(d[i*ELEM_W +: ELEM_W]);
        end
        e.lane0 = s[ELEM_W-1:0];
        e.due   = cyc + LAT;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Present garbage with in_valid low for n cycles.
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = {LANES{16'hBEEF}};
            in_mask  = '1;
        end
    endtask

    // Monitor: compare results against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_data[LANES*ELEM_W-1:ELEM_W] == '0, "R2", 0, 0);
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.due == cyc, "R6 latency", cyc, e.due);
                    check(out_data[ELEM_W-1:0] == e.lane0, e.tag,
                          longint'(out_data[ELEM_W-1:0]), longint'(e.lane0));
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(1'b0, "R6 missing result", 0, 1);
                check(1'b0, "R7 order", 0, longint'(e.lane0));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [LANES*ELEM_W-1:0] d;
        // R8: outputs quiet during reset even with valid input presented.
        in_valid = 1'b1;
        in_data  = {LANES{16'h1234}};
        in_mask  = '1;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8 reset", out_valid, 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R8: idle garbage after reset gives no result.
        for (int k = 0; k < 6; k++) begin
            idle(1);
            check(out_valid == 1'b0, "R8 idle", out_valid, 0);
        end

        // R1: all lanes selected, small values 1..8 -> 36.
        for (int i = 0; i < LANES; i++) d[i*ELEM_W +: ELEM_W] = ELEM_W'(i + 1);
        drive(d, '1, "R1 all lanes");
        // R4: no lane selected with nonzero data.
        drive({LANES{16'hFFFF}}, '0, "R4 empty mask");
        // R3: odd lanes large but unselected.
        for (int i = 0; i < LANES; i++) d[i*ELEM_W +: ELEM_W] = (i % 2) ? 16'hF00D : ELEM_W'(i * 3);
        drive(d, 8'h55, "R3 masked lanes ignored");
        // R5: every lane at max -> wraps to 0xFFF8.
        drive({LANES{16'hFFFF}}, '1, "R5 wide wrap");
        // R1: only the top lane.
        drive({16'h7ABC, {(LANES-1){16'h1111}}}, 8'h80, "R1 top lane");
        // R1: signed view, -1 + 1 wraps to 0.
        drive({{(LANES-2){16'h0}}, 16'h0001, 16'hFFFF}, 8'h03, "R1 signed wrap");
        idle(2);
        check(sb.size() <= LAT, "R6 drain", sb.size(), LAT);

        // R7: long back-to-back burst of random vectors.
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < LANES; i++) d[i*ELEM_W +: ELEM_W] = ELEM_W'($urandom);
            drive(d, LANES'($urandom), "R7 burst");
        end
        idle(1);
        // R4 and R5 interleaved back-to-back.
        drive({LANES{16'hFFFF}}, '1, "R5 wide wrap burst");
        drive({LANES{16'hABCD}}, '0, "R4 empty mask burst");
        drive({LANES{16'h8000}}, '1, "R5 half range");
        idle(LAT + 4);
        check(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
        finish_run();
    end

endmodule